// File: doc/BRIEF.md
# Serial Flash Recovery Pulse Sequencer

This block sits on the controller side of a quad-capable serial flash link. It produces the first step of the recovery procedure. That step is needed when the memory has lost sync with the controller, or when it has powered up in an unknown protocol width or in execute-in-place mode. A single start pulse sets off six chip-select-low windows. The windows hold 7, 9, 13, 17, 25 and 33 SPI clock rising edges, in that order. Data lines 0 and 3 are driven high throughout every window. Chip select is raised exactly where the next rising edge would have fallen, so whatever partial command the flash has decoded is dropped, whatever bus width it believes it is in.

The SPI clock runs at the system clock divided by `CLK_DIV`. The chip-select-high time between windows is `GAP_CYCLES` system clocks, and never less than one SPI period. A designer sets `GAP_CYCLES` by rounding 50 ns up to whole system clock periods. Data line 1 is never driven. Data line 2 is driven high during windows only when `DQ2_DRIVE` is set. When the last gap expires the block pulses `done_o`, and a follow-on block then issues the second recovery step. Only the flash interface is affected, so the controller must not assume that a program or erase already running inside the flash was stopped.

Top module: `flash_rescue_seq`

## Requirements
- R1: After an accepted start, exactly six chip-select-low windows occur. Counting the rising edges of `sck_o` in each window gives 7, 9, 13, 17, 25, 33 in that order.
- R2: `sck_o` is low whenever `cs_n_o` is high. The first rising edge of a window comes `CLK_DIV/2` system clocks after `cs_n_o` falls. `cs_n_o` rises `CLK_DIV/2` system clocks after the last falling edge, in the slot where the next rising edge would have been.
- R3: While `cs_n_o` is low, `dq_oe_o[0]`, `dq_oe_o[3]`, `dq_out_o[0]` and `dq_out_o[3]` are all 1.
- R4: `dq_oe_o[1]` is always 0. While `cs_n_o` is low, `dq_oe_o[2]` equals `DQ2_DRIVE` and a driven `dq_out_o[2]` is 1. While `cs_n_o` is high, all four bits of `dq_oe_o` are 0.
- R5: Between consecutive windows, `cs_n_o` stays high for at least max(`GAP_CYCLES`, `CLK_DIV`) system clocks.
- R6: `busy_o` is 1 from the cycle after an accepted start. `done_o` is high for exactly one system clock, in the first cycle after the sixth gap expires. In that same cycle `busy_o` is 0.
- R7: A `start_i` pulse while `busy_o` is 1 is ignored. The running sequence keeps its six windows and lengths, and no second sequence follows once `done_o` has pulsed.
- R8: After reset `cs_n_o`=1, `sck_o`=0, `dq_oe_o`=0, `busy_o`=0 and `done_o`=0.
- R9: Once `done_o` has pulsed, a new start begins a complete fresh sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a recovery pulse sequence (accepted only when idle) |
| cs_n_o | output | 1 | Flash chip select, active low |
| sck_o | output | 1 | SPI clock to the flash |
| dq_oe_o | output | 4 | Output enables for data lines 0 to 3 |
| dq_out_o | output | 4 | Values driven on data lines 0 to 3 |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse at sequence completion |

## Verification
The assertions assume that `start_i` is synchronous to `clk` and changes only between edges. They also assume `CLK_DIV` is even and at least 2, so that each half SPI period is a whole number of system clocks. The gap check assumes that the chip-select-high time before the first window of a sequence may be arbitrarily short, so it only measures gaps after the first window. The bench drives `start_i` on falling clock edges with one-cycle pulses. It places the extra pulses inside a running sequence, and it restarts only after `done_o` has been seen.

// File: rtl/flash_rescue_pkg.sv
package flash_rescue_pkg;

    localparam int NUM_BURSTS = 6;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEL_LO,
        ST_SEL_HI,
        ST_GAP
    } rescue_state_e;

    typedef struct packed {
        rescue_state_e st;
        logic          cs_n;
        logic          sck;
        logic [2:0]    idx;
        logic [5:0]    edges;
        logic          done;
    } rescue_seq_t;

    // Rising-edge count for each select-low window, in issue order.
    function automatic logic [5:0] burst_len(input logic [2:0] idx);
        case (idx)
            3'd0:    burst_len = 6'd7;
            3'd1:    burst_len = 6'd9;
            3'd2:    burst_len = 6'd13;
            3'd3:    burst_len = 6'd17;
            3'd4:    burst_len = 6'd25;
            default: burst_len = 6'd33;
        endcase
    endfunction

endpackage

// File: rtl/rescue_down_counter.sv
module rescue_down_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/rescue_pad_drive.sv
module rescue_pad_drive #(
    parameter int                    NUM_PADS   = 4,
    parameter logic [NUM_PADS-1:0]   DRIVE_MASK = '1
) (
    input  logic                active_i,
    output logic [NUM_PADS-1:0] oe_o,
    output logic [NUM_PADS-1:0] out_o
);

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        if (DRIVE_MASK[p]) begin : g_drive
            assign oe_o[p]  = active_i;
            assign out_o[p] = active_i;
        end else begin : g_float
            assign oe_o[p]  = 1'b0;
            assign out_o[p] = 1'b0;
        end
    end

endmodule

// File: rtl/flash_rescue_seq.sv
module flash_rescue_seq
    import flash_rescue_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int GAP_CYCLES = 6,
    parameter bit DQ2_DRIVE  = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    output logic       cs_n_o,
    output logic       sck_o,
    output logic [3:0] dq_oe_o,
    output logic [3:0] dq_out_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int HALF    = CLK_DIV / 2;
    localparam int GAP_EFF = (GAP_CYCLES > CLK_DIV) ? GAP_CYCLES : CLK_DIV;
    localparam int CW      = $clog2(GAP_EFF + 1);
    localparam logic [3:0] PAD_MASK = {1'b1, DQ2_DRIVE, 1'b0, 1'b1};

    rescue_seq_t   seq_d, seq_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic [5:0]    cur_len;

    assign cur_len = burst_len(seq_q.idx);

    rescue_down_counter #(.W(CW)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        case (seq_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.st    = ST_SEL_LO;
                    seq_d.cs_n  = 1'b0;
                    seq_d.sck   = 1'b0;
                    seq_d.idx   = '0;
                    seq_d.edges = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(HALF - 1);
                end
            end
            ST_SEL_LO: begin
                if (tmr_zero) begin
                    tmr_load = 1'b1;
                    if (seq_q.edges == cur_len) begin
                        // The slot of the would-be next rising edge: deselect.
                        seq_d.st   = ST_GAP;
                        seq_d.cs_n = 1'b1;
                        tmr_val    = CW'(GAP_EFF - 1);
                    end else begin
                        seq_d.st    = ST_SEL_HI;
                        seq_d.sck   = 1'b1;
                        seq_d.edges = seq_q.edges + 6'd1;
                        tmr_val     = CW'(HALF - 1);
                    end
                end
            end
            ST_SEL_HI: begin
                if (tmr_zero) begin
                    seq_d.st  = ST_SEL_LO;
                    seq_d.sck = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = CW'(HALF - 1);
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    if (seq_q.idx == 3'(NUM_BURSTS - 1)) begin
                        seq_d.st   = ST_IDLE;
                        seq_d.done = 1'b1;
                    end else begin
                        seq_d.st    = ST_SEL_LO;
                        seq_d.cs_n  = 1'b0;
                        seq_d.idx   = seq_q.idx + 3'd1;
                        seq_d.edges = '0;
                        tmr_load    = 1'b1;
                        tmr_val     = CW'(HALF - 1);
                    end
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, cs_n: 1'b1, sck: 1'b0, idx: '0, edges: '0, done: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    rescue_pad_drive #(.NUM_PADS(4), .DRIVE_MASK(PAD_MASK)) u_pads (
        .active_i (!seq_q.cs_n),
        .oe_o     (dq_oe_o),
        .out_o    (dq_out_o)
    );

    assign cs_n_o = seq_q.cs_n;
    assign sck_o  = seq_q.sck;
    assign busy_o = (seq_q.st != ST_IDLE);
    assign done_o = seq_q.done;

    // Support counter for the gap assertion: cycles spent deselected.
    logic [CW-1:0] hi_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q <= '0;
        end else if (!cs_n_o) begin
            hi_run_q <= '0;
        end else if (hi_run_q != CW'(GAP_EFF)) begin
            hi_run_q <= hi_run_q + 1'b1;
        end
    end

    a_r2_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_o |-> !sck_o);

    a_r3_pads_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n_o |-> (dq_oe_o[0] && dq_oe_o[3] && dq_out_o[0] && dq_out_o[3]));

    a_r4_dq1_released: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe_o[1]);

    a_r1_edges_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.edges <= cur_len);

    a_r5_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n_o) && seq_q.idx != 3'd0) |-> (hi_run_q >= CW'(GAP_EFF)));

    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r7_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(seq_q.st == ST_GAP && tmr_zero && seq_q.idx == 3'(NUM_BURSTS - 1))) |=> busy_o);

endmodule

// File: tb/flash_rescue_seq_tb.sv
module flash_rescue_seq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int GAP        = 6;
    localparam bit DQ2        = 1'b1;
    localparam int HALF       = DIV / 2;
    localparam int GAP_EFF    = (GAP > DIV) ? GAP : DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       cs_n_o, sck_o, busy_o, done_o;
    logic [3:0] dq_oe_o, dq_out_o;

    int n_chk = 0;
    int n_fail = 0;

    int exp_len [6] = '{7, 9, 13, 17, 25, 33};

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_rescue_seq #(.CLK_DIV(DIV), .GAP_CYCLES(GAP), .DQ2_DRIVE(DQ2)) u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cs_n_o   (cs_n_o),
        .sck_o    (sck_o),
        .dq_oe_o  (dq_oe_o),
        .dq_out_o (dq_out_o),
        .busy_o   (busy_o),
        .done_o   (done_o)
    );

    // Monitor state, sampled on falling clock edges.
    int   edge_cnt, tail, hi_len, nwin, min_gap;
    int   win [8];
    int   timing_bad, pad_bad, sck_hi_bad, done_cnt, done_bad;
    logic cs_prev = 1'b1, sck_prev = 1'b0, done_prev = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                done_cnt++;
                if (busy_o) done_bad++;
                if (done_prev) done_bad++;
            end
            if (!cs_n_o) begin
                if (dq_oe_o[0] !== 1'b1 || dq_oe_o[3] !== 1'b1 ||
                    dq_out_o[0] !== 1'b1 || dq_out_o[3] !== 1'b1) pad_bad++;
                if (dq_oe_o[1] !== 1'b0 || dq_oe_o[2] !== DQ2) pad_bad++;
                if (DQ2 && dq_out_o[2] !== 1'b1) pad_bad++;
                if (cs_prev) begin
                    if (nwin > 0 && hi_len < GAP_EFF) timing_bad++;
                    if (nwin > 0 && hi_len < min_gap) min_gap = hi_len;
                    edge_cnt = 0;
                    tail = 0;
                end
                if (sck_o) begin
                    if (!sck_prev) begin
                        if (edge_cnt == 0 && tail != HALF) timing_bad++;
                        edge_cnt++;
                    end
                    tail = 0;
                end else begin
                    tail++;
                end
            end else begin
                if (sck_o) sck_hi_bad++;
                if (dq_oe_o !== 4'b0000) pad_bad++;
                if (!cs_prev) begin
                    if (tail != HALF) timing_bad++;
                    if (nwin < 8) win[nwin] = edge_cnt;
                    nwin++;
                    hi_len = 0;
                end
                hi_len++;
            end
            cs_prev   = cs_n_o;
            sck_prev  = sck_o;
            done_prev = done_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        edge_cnt = 0; tail = 0; hi_len = 0; nwin = 0; min_gap = 1000;
        timing_bad = 0; pad_bad = 0; sck_hi_bad = 0; done_cnt = 0; done_bad = 0;
        foreach (win[i]) win[i] = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done();
        for (int c = 0; c < 5000 && done_cnt == 0; c++) @(negedge clk);
    endtask

    // R8: reset values at the ports
    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(cs_n_o === 1'b1, "R8 cs_n in reset", int'(cs_n_o), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n_o === 1'b1, "R8 cs_n after reset", int'(cs_n_o), 1);
        check(sck_o === 1'b0, "R8 sck after reset", int'(sck_o), 0);
        check(dq_oe_o === 4'b0000, "R8 oe after reset", int'(dq_oe_o), 0);
        check(busy_o === 1'b0 && done_o === 1'b0, "R8 busy/done after reset",
              int'({busy_o, done_o}), 0);
    endtask

    // One full sequence; extra_starts pulses land while busy (R7)
    task automatic run_seq(input string tag, input int extra_starts);
        clear_mon();
        pulse_start();
        check(busy_o === 1'b1, {tag, " R6 busy after start"}, int'(busy_o), 1);
        for (int k = 0; k < extra_starts; k++) begin
            repeat (37) @(negedge clk);
            pulse_start();
        end
        wait_done();
        check(done_cnt == 1, {tag, " R6 done seen once"}, done_cnt, 1);
        check(done_bad == 0, {tag, " R6 done single cycle with busy low"}, done_bad, 0);
        check(nwin == 6, {tag, " R1 window count"}, nwin, 6);
        for (int i = 0; i < 6; i++)
            check(win[i] == exp_len[i], {tag, " R1 rising edges in window"}, win[i], exp_len[i]);
        check(timing_bad == 0, {tag, " R2 lead/tail half period"}, timing_bad, 0);
        check(sck_hi_bad == 0, {tag, " R2 sck low while deselected"}, sck_hi_bad, 0);
        check(pad_bad == 0, {tag, " R3 R4 data line drive"}, pad_bad, 0);
        check(min_gap >= GAP_EFF, {tag, " R5 minimum deselect"}, min_gap, GAP_EFF);
        repeat (30) @(negedge clk);
        check(busy_o === 1'b0 && nwin == 6, {tag, " R7 no queued restart"}, nwin, 6);
        check(cs_n_o === 1'b1 && dq_oe_o === 4'b0000, {tag, " R4 idle release"},
              int'(dq_oe_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        test_reset();
        run_seq("basic", 0);
        run_seq("R7 starts while busy", 5);
        run_seq("R9 restart after done", 0);
        test_reset();
        run_seq("R9 after second reset", 2);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule